// File: doc/BRIEF.md
# Hybrid multi-level bus arbiter

This block decides which of several bus masters may drive a shared bus. The masters are grouped into four request levels. Each level has its own request line into the arbiter and its own grant line out of it. Inside a level the masters sit on a daisy chain. The level grant enters the chain at master 0 and moves along it until it reaches a master that wants the bus. The arbiter captures that chain result when it issues the grant and holds it in a register until the bus is released.

Ownership is non-preemptive and lasts one transaction. The owning master raises `busy_i` in the first cycle its grant is visible and keeps it high until the transfer is done. The first rising edge that sees `busy_i` low ends the ownership. The next owner is chosen in a later idle cycle.

Two priority schemes are available, and `rot_mode_i` picks one. In the fixed scheme, a request on a level above the owner's level pulls the active-low bus-clear output down, which asks the owner to finish early. In the rotating scheme, the level granted most recently ranks last in the next arbitration.

Top module: `hybrid_bus_arbiter`

## Requirements
- R1: In fixed mode (`rot_mode_i`=0 at the arbitration edge), the level granted is the highest-numbered level whose `lvl_req_i` bit is set. Level 3 ranks highest and level 0 lowest.
- R2: In rotating mode (`rot_mode_i`=1), after level L was granted last, the ranking from highest to lowest is L-1, L-2, … wrapping modulo 4, ending with L. The last-granted level is recorded on every grant in either mode. After reset it reads as level 0.
- R3: Grant bit `mst_gnt_o[l*CHAIN_LEN+i]` belongs to master i of level l, and master 0 is first on the chain. Only the granted level's chain receives a grant. Inside that chain, the master granted is the lowest-index master whose `want_i` bit was set at the arbitration edge. If no master in the level wants the bus, every chain bit stays low while the level grant is still given.
- R4: Grants are registered. A grant is issued at the first rising edge at which the arbiter is idle, some `lvl_req_i` bit is set and `busy_i` is low. The grant is visible after that edge as a one-hot `lvl_gnt_o`.
- R5: While `busy_i` is high at each rising edge, the grant and the chain grant do not change. The owner must raise `busy_i` in its first granted cycle. At the first edge that sees `busy_i` low with a grant active, all grants return to zero, and requests that arrived in the meantime have no effect.
- R6: At most one level grant and at most one chain grant are active at any time. Between two owners there is at least one cycle with all grants low.
- R7: In fixed mode, while the bus is owned and `busy_i` is high, an edge that sees a request on a level above the owner's level drives `bclr_n_o` low after that edge. A request on the owner's level or on a lower level leaves `bclr_n_o` high. `bclr_n_o` returns high at the release edge and stays high whenever no grant is active.
- R8: In rotating mode, `bclr_n_o` stays high during ownership, even while a higher level is requesting.
- R9: The mode is captured at the arbitration edge. Changing `rot_mode_i` during an ownership has no effect on that ownership's bus-clear behaviour.
- R10: During and right after reset, all grants are low and `bclr_n_o` is high.
- R11: An idle edge that sees `busy_i` high issues no grant, even while requests are pending. The grant follows at the first idle edge that sees `busy_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rot_mode_i | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| lvl_req_i | input | 4 | Request line per level |
| want_i | input | 4*CHAIN_LEN | Want-bus flag per chained master, level-major |
| busy_i | input | 1 | Bus busy indication from the current owner |
| lvl_gnt_o | output | 4 | Registered grant per level, one-hot or zero |
| mst_gnt_o | output | 4*CHAIN_LEN | Registered grant per chained master |
| bclr_n_o | output | 1 | Bus clear request, active low |

## Verification
Fixed mode is swept over all fifteen non-zero request patterns, each combined with all eight want patterns applied to every chain. This separates the level ranking from the chain ranking and shows that masters outside the winning level never receive a grant. Rotating mode is first driven with every level requesting continuously, which exposes the full rotation order. It is then swept over all request patterns, which checks that the last-granted pointer carries across grants, including grants made in fixed mode. Directed sequences put requests below, at and above the owner's level in both modes. They flip the mode during an ownership and raise requests while `busy_i` is held in an idle cycle, which separates the preemption request and the mode capture from plain release sequencing.

// File: rtl/hba_pkg.sv
package hba_pkg;

    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OWNED = 1'b1
    } own_state_e;

    typedef struct packed {
        logic             fixed;
        logic [LVL_W-1:0] lvl;
    } owner_t;

    // Level at rank distance d (1 = next) below the last granted one.
    function automatic logic [LVL_W-1:0] rot_index(input logic [LVL_W-1:0] last,
                                                   input int d);
        return LVL_W'((int'(last) + NUM_LVL - d) % NUM_LVL);
    endfunction

endpackage

// File: rtl/hba_level_pick.sv
module hba_level_pick
    import hba_pkg::*;
(
    input  logic [NUM_LVL-1:0] req,
    input  logic               rot,
    input  logic [LVL_W-1:0]   last,
    output logic               any,
    output logic [LVL_W-1:0]   win
);
    logic [LVL_W-1:0] fix_win;
    logic [LVL_W-1:0] rot_win;

    always_comb begin
        fix_win = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (req[i]) fix_win = LVL_W'(i);
        end
        rot_win = '0;
        for (int d = NUM_LVL; d >= 1; d--) begin
            if (req[rot_index(last, d)]) rot_win = rot_index(last, d);
        end
    end

    assign any = |req;
    assign win = rot ? rot_win : fix_win;
endmodule

// File: rtl/hba_chain.sv
module hba_chain #(
    parameter int LEN = 3
) (
    input  logic           gin,
    input  logic [LEN-1:0] want,
    output logic [LEN-1:0] gout
);
    logic [LEN:0] carry;

    assign carry[0] = gin;

    for (genvar i = 0; i < LEN; i++) begin : g_link
        assign gout[i]    = carry[i] & want[i];
        assign carry[i+1] = carry[i] & ~want[i];
    end
endmodule

// File: rtl/hba_preempt.sv
module hba_preempt
    import hba_pkg::*;
(
    input  logic [NUM_LVL-1:0] req,
    input  logic [LVL_W-1:0]   owner,
    output logic               higher
);
    always_comb begin
        higher = 1'b0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (req[i] && (LVL_W'(i) > owner)) higher = 1'b1;
        end
    end
endmodule

// File: rtl/hybrid_bus_arbiter.sv
module hybrid_bus_arbiter
    import hba_pkg::*;
#(
    parameter int CHAIN_LEN = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           rot_mode_i,
    input  logic [NUM_LVL-1:0]             lvl_req_i,
    input  logic [NUM_LVL*CHAIN_LEN-1:0]   want_i,
    input  logic                           busy_i,
    output logic [NUM_LVL-1:0]             lvl_gnt_o,
    output logic [NUM_LVL*CHAIN_LEN-1:0]   mst_gnt_o,
    output logic                           bclr_n_o
);
    localparam int NUM_MST = NUM_LVL * CHAIN_LEN;

    own_state_e          st_q;
    owner_t              own_q;
    logic [LVL_W-1:0]    last_q;
    logic [NUM_LVL-1:0]  lvl_gnt_q;
    logic [NUM_MST-1:0]  mst_gnt_q;
    logic                bclr_n_q;

    logic                pick_any;
    logic [LVL_W-1:0]    pick_win;
    logic [NUM_LVL-1:0]  win_onehot;
    logic [NUM_MST-1:0]  chain_gnt;
    logic                higher_req;

    hba_level_pick u_pick (
        .req  (lvl_req_i),
        .rot  (rot_mode_i),
        .last (last_q),
        .any  (pick_any),
        .win  (pick_win)
    );

    assign win_onehot = pick_any ? (NUM_LVL'(1) << pick_win) : '0;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        hba_chain #(.LEN(CHAIN_LEN)) u_chain (
            .gin  (win_onehot[l]),
            .want (want_i[l*CHAIN_LEN +: CHAIN_LEN]),
            .gout (chain_gnt[l*CHAIN_LEN +: CHAIN_LEN])
        );
    end

    hba_preempt u_pre (
        .req    (lvl_req_i),
        .owner  (own_q.lvl),
        .higher (higher_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            own_q     <= '0;
            last_q    <= '0;
            lvl_gnt_q <= '0;
            mst_gnt_q <= '0;
            bclr_n_q  <= 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    bclr_n_q <= 1'b1;
                    if (pick_any && !busy_i) begin
                        st_q      <= ST_OWNED;
                        own_q     <= '{fixed: !rot_mode_i, lvl: pick_win};
                        last_q    <= pick_win;
                        lvl_gnt_q <= win_onehot;
                        mst_gnt_q <= chain_gnt;
                    end
                end
                ST_OWNED: begin
                    if (!busy_i) begin
                        st_q      <= ST_IDLE;
                        lvl_gnt_q <= '0;
                        mst_gnt_q <= '0;
                        bclr_n_q  <= 1'b1;
                    end else begin
                        bclr_n_q  <= !(own_q.fixed && higher_req);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign lvl_gnt_o = lvl_gnt_q;
    assign mst_gnt_o = mst_gnt_q;
    assign bclr_n_o  = bclr_n_q;
endmodule

// File: rtl/hba_chk.sv
module hba_chk
    import hba_pkg::*;
#(
    parameter int CHAIN_LEN = 3
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         busy_i,
    input logic [NUM_LVL-1:0]           lvl_req_i,
    input logic [NUM_LVL-1:0]           lvl_gnt_o,
    input logic [NUM_LVL*CHAIN_LEN-1:0] mst_gnt_o,
    input logic                         bclr_n_o
);
    logic [NUM_LVL-1:0] mst_lvl;

    always_comb begin
        for (int l = 0; l < NUM_LVL; l++) begin
            mst_lvl[l] = |mst_gnt_o[l*CHAIN_LEN +: CHAIN_LEN];
        end
    end

    assert_single_level_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lvl_gnt_o));

    assert_single_master_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mst_gnt_o));

    assert_chain_in_level_R3: assert property (@(posedge clk) disable iff (rst)
        (mst_lvl & ~lvl_gnt_o) == '0);

    assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
        ((|lvl_gnt_o) && busy_i) |=> ($stable(lvl_gnt_o) && $stable(mst_gnt_o)));

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        ((|lvl_gnt_o) && !busy_i) |=> (lvl_gnt_o == '0));

    assert_grant_start_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(|lvl_gnt_o) |-> (!$past(busy_i) && ($past(lvl_req_i) != '0)));

    assert_clear_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (lvl_gnt_o == '0) |-> bclr_n_o);

    assert_clear_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(bclr_n_o) |-> ($past(busy_i) && ($past(lvl_req_i) != '0)));
endmodule

bind hybrid_bus_arbiter hba_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_i    (busy_i),
    .lvl_req_i (lvl_req_i),
    .lvl_gnt_o (lvl_gnt_o),
    .mst_gnt_o (mst_gnt_o),
    .bclr_n_o  (bclr_n_o)
);

// File: tb/hybrid_bus_arbiter_tb.sv
`timescale 1ns/1ps
module hybrid_bus_arbiter_tb;
    localparam int CL = 3;
    localparam int NM = 4 * CL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rot_mode_i = 1'b0;
    logic [3:0]    lvl_req_i = '0;
    logic [NM-1:0] want_i = '0;
    logic          busy_i = 1'b0;
    logic [3:0]    lvl_gnt_o;
    logic [NM-1:0] mst_gnt_o;
    logic          bclr_n_o;

    int total = 0;
    int fails = 0;
    int last_lvl = 0;

    always #2.5 clk = ~clk;

    hybrid_bus_arbiter #(.CHAIN_LEN(CL)) u_dut (
        .clk(clk), .rst(rst), .rot_mode_i(rot_mode_i), .lvl_req_i(lvl_req_i),
        .want_i(want_i), .busy_i(busy_i), .lvl_gnt_o(lvl_gnt_o),
        .mst_gnt_o(mst_gnt_o), .bclr_n_o(bclr_n_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_win(input logic [3:0] req, input bit rot, input int last);
        int w = 0;
        if (!rot) begin
            for (int i = 0; i < 4; i++) if (req[i]) w = i;
        end else begin
            for (int d = 4; d >= 1; d--) if (req[(last + 4 - d) % 4]) w = (last + 4 - d) % 4;
        end
        return w;
    endfunction

    function automatic logic [NM-1:0] model_chain(input int lvl, input logic [CL-1:0] w);
        logic [NM-1:0] m = '0;
        for (int i = CL - 1; i >= 0; i--) begin
            if (w[i]) begin
                m = '0;
                m[lvl*CL + i] = 1'b1;
            end
        end
        return m;
    endfunction

    // Called at a negedge with the arbiter idle; leaves the owner busy.
    task automatic start_grant(input logic [3:0] req, input logic [CL-1:0] w,
                               input bit rot, input string tag);
        int win;
        win = model_win(req, rot, last_lvl);
        rot_mode_i = rot;
        lvl_req_i  = req;
        want_i     = {4{w}};
        busy_i     = 1'b0;
        @(negedge clk);
        chk(tag, 32'(lvl_gnt_o), 32'(4'b1 << win));
        chk("R3 chain grant", 32'(mst_gnt_o), 32'(model_chain(win, w)));
        chk("R7 clear high at grant", 32'(bclr_n_o), 32'd1);
        last_lvl = win;
        busy_i    = 1'b1;
        lvl_req_i = '0;
    endtask

    task automatic end_grant(input logic [3:0] exp_lvl);
        logic [NM-1:0] held;
        held = mst_gnt_o;
        @(negedge clk);
        chk("R5 grant held", 32'(lvl_gnt_o), 32'(exp_lvl));
        chk("R5 chain held", 32'(mst_gnt_o), 32'(held));
        busy_i    = 1'b0;
        lvl_req_i = 4'b1111;
        @(negedge clk);
        chk("R5 release clears", 32'(lvl_gnt_o), 32'd0);
        chk("R6 gap chain low", 32'(mst_gnt_o), 32'd0);
        chk("R7 clear high after release", 32'(bclr_n_o), 32'd1);
        lvl_req_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R4 watchdog act=%0d exp=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset grants", 32'(lvl_gnt_o), 32'd0);
        chk("R10 reset chain", 32'(mst_gnt_o), 32'd0);
        chk("R10 reset clear", 32'(bclr_n_o), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 after reset grants", 32'(lvl_gnt_o), 32'd0);
        chk("R10 after reset clear", 32'(bclr_n_o), 32'd1);

        // R1 and R3: fixed-priority sweep over all requests and want patterns
        for (int r = 1; r < 16; r++) begin
            for (int w = 0; w < 8; w++) begin
                start_grant(4'(r), 3'(w), 1'b0, "R1 fixed level");
                end_grant(4'b1 << last_lvl);
            end
        end

        // R2: all levels requesting, rotation order
        for (int k = 0; k < 8; k++) begin
            start_grant(4'b1111, 3'b100, 1'b1, "R2 rotating all");
            end_grant(4'b1 << last_lvl);
        end
        // R2: rotating sweep over request patterns
        for (int r = 1; r < 16; r++) begin
            for (int rep = 0; rep < 3; rep++) begin
                start_grant(4'(r), 3'(r + rep), 1'b1, "R2 rotating level");
                end_grant(4'b1 << last_lvl);
            end
        end

        // R7: lower and same requests keep clear high, higher request pulls it low
        start_grant(4'b0010, 3'b010, 1'b0, "R1 fixed owner");
        lvl_req_i = 4'b0011;
        @(negedge clk);
        chk("R7 lower request no clear", 32'(bclr_n_o), 32'd1);
        lvl_req_i = 4'b1000;
        want_i    = {4{3'b001}};
        @(negedge clk);
        chk("R7 higher request clears", 32'(bclr_n_o), 32'd0);
        chk("R5 owner kept during clear", 32'(lvl_gnt_o), 32'b0010);
        @(negedge clk);
        chk("R7 clear stays low", 32'(bclr_n_o), 32'd0);
        busy_i = 1'b0;
        @(negedge clk);
        chk("R7 release after clear", 32'(lvl_gnt_o), 32'd0);
        chk("R7 clear released", 32'(bclr_n_o), 32'd1);
        @(negedge clk);
        chk("R4 higher level granted next", 32'(lvl_gnt_o), 32'b1000);
        chk("R3 chain of preemptor", 32'(mst_gnt_o), 32'(model_chain(3, 3'b001)));
        last_lvl  = 3;
        busy_i    = 1'b1;
        lvl_req_i = '0;
        end_grant(4'b1000);

        // R8: rotating mode never clears
        start_grant(4'b0010, 3'b001, 1'b1, "R2 rotating owner");
        lvl_req_i = 4'b1100;
        @(negedge clk);
        chk("R8 rotating no clear", 32'(bclr_n_o), 32'd1);
        @(negedge clk);
        chk("R8 rotating still no clear", 32'(bclr_n_o), 32'd1);
        lvl_req_i = '0;
        end_grant(4'b0010);

        // R9: mode change during ownership is ignored
        start_grant(4'b0001, 3'b111, 1'b0, "R1 fixed owner");
        rot_mode_i = 1'b1;
        lvl_req_i  = 4'b0100;
        @(negedge clk);
        chk("R9 fixed captured, clear low", 32'(bclr_n_o), 32'd0);
        lvl_req_i = '0;
        end_grant(4'b0001);
        start_grant(4'b0001, 3'b110, 1'b1, "R2 rotating owner");
        rot_mode_i = 1'b0;
        lvl_req_i  = 4'b1000;
        @(negedge clk);
        chk("R9 rotating captured, clear high", 32'(bclr_n_o), 32'd1);
        lvl_req_i = '0;
        end_grant(4'b0001);

        // R11: busy seen while idle blocks the grant
        rot_mode_i = 1'b0;
        busy_i     = 1'b1;
        lvl_req_i  = 4'b0100;
        want_i     = {4{3'b000}};
        @(negedge clk);
        chk("R11 no grant while busy", 32'(lvl_gnt_o), 32'd0);
        @(negedge clk);
        chk("R11 still no grant", 32'(lvl_gnt_o), 32'd0);
        busy_i = 1'b0;
        @(negedge clk);
        chk("R11 grant after busy drops", 32'(lvl_gnt_o), 32'b0100);
        chk("R3 empty chain no master", 32'(mst_gnt_o), 32'd0);
        last_lvl  = 2;
        busy_i    = 1'b1;
        lvl_req_i = '0;
        end_grant(4'b0100);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule